// File: doc/BRIEF.md
# Wavefront Fetch Eligibility Arbiter

This block watches a set of wavefront slots and decides, once per clock, which slot may start an instruction fetch. For every slot it receives a running flag, the occupancy of that slot's instruction buffer and a flag saying whether a branch sits in that buffer. It keeps two bits of its own per slot: a pending-fetch bit and a queued bit. It also keeps an ordered list of slots that are waiting for a grant.

On each clock edge, every slot that is not queued is tested. A slot that passes the test is appended to the ordered list, with the lowest slot index going first. If the list is then non-empty, its oldest entry is removed and granted. The grant is a registered pulse that carries the slot number. At the same edge the granted slot's pending bit is set and its queued bit is cleared. A fetch-return pulse that names a slot clears that slot's pending bit, so the slot can be tested again.

The list controller has two states. **ST_EMPTY** means no slot is waiting. **ST_HOLD** means one or more slots are waiting.
- EMPTY→EMPTY: at most one slot joins, and it is granted at once.
- EMPTY→HOLD: two or more slots join; one is granted and the others stay.
- HOLD→HOLD: entries still remain after the grant.
- HOLD→EMPTY: the last waiting entry is granted.

Top module: `wave_fetch_arbiter`

## Requirements
- R1: After reset, grant_valid_o is 0, grant_slot_o is 0, and every bit of pending_o and queued_o is 0.
- R2: A slot that is not queued and not pending joins the list only when all of these hold: run_i is 1, its occupancy field (occ_i bits [j*OCC_W +: OCC_W]) is at most OCC_LIMIT (default 4), and br_i is 0. An occupancy of OCC_LIMIT+1 or more, a set branch flag, or a cleared run flag keeps it out.
- R3: When the list is empty and no slot joins in a cycle, no grant is issued.
- R4: At most one slot is granted per edge. grant_valid_o is a one-cycle pulse per grant, and the same slot is never granted on two consecutive edges.
- R5: At the edge that grants a slot, that slot's pending_o bit becomes 1 and its queued_o bit becomes 0.
- R6: Grants are oldest-first. An entry that joined on an earlier edge is granted before any entry that joined later.
- R7: Slots that join on the same edge enter the list in ascending slot-index order. A slot that is alone on an empty list is granted on the same edge it joins.
- R8: A pulse on ret_valid_i with slot number ret_slot_i clears that slot's pending_o bit at that edge. If the slot still meets the R2 conditions, it can be granted on the following edge.
- R9: A queued slot is not tested again. It is granted exactly once, even if its inputs stop meeting the R2 conditions while it waits, and no slot is ever both queued and pending.
- R10: While a slot's pending_o bit is 1, the slot is not granted, whatever its inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | N_SLOTS | Per-slot running flag |
| occ_i | input | N_SLOTS*OCC_W | Per-slot buffer occupancy, slot j in bits [j*OCC_W +: OCC_W] |
| br_i | input | N_SLOTS | Per-slot branch-in-buffer flag |
| ret_valid_i | input | 1 | Fetch-return pulse |
| ret_slot_i | input | IDW | Slot named by the fetch return |
| grant_valid_o | output | 1 | Registered grant pulse |
| grant_slot_o | output | IDW | Granted slot number, 0 when no grant |
| pending_o | output | N_SLOTS | Per-slot pending-fetch bits |
| queued_o | output | N_SLOTS | Per-slot queued bits |

## Verification
Every result is registered, so a decision made from the inputs present before rising edge k shows up on the ports just after edge k. This applies to the grant, the pending bits and the queued bits alike. A return pulse takes effect at its own edge, and the cleared slot can first be granted one edge later. The bench changes its inputs on falling edges and compares the outputs on the falling edge that follows each rising edge, so each check looks at exactly one decision.

The checks cover several parts of the behaviour. A single slot is swept through every occupancy value together with the run and branch flags. Directed sequences check the ascending and oldest-first orderings. A long pseudo-random run is compared on every cycle against an arithmetic list model kept in the bench.

// File: rtl/wfa_pkg.sv
package wfa_pkg;
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HOLD  = 1'b1
    } wfa_state_e;
endpackage

// File: rtl/wfa_elig.sv
module wfa_elig #(
    parameter int N_SLOTS   = 4,
    parameter int OCC_W     = 4,
    parameter int OCC_LIMIT = 4
) (
    input  logic [N_SLOTS-1:0]       run_i,
    input  logic [N_SLOTS*OCC_W-1:0] occ_i,
    input  logic [N_SLOTS-1:0]       br_i,
    input  logic [N_SLOTS-1:0]       pending_i,
    input  logic [N_SLOTS-1:0]       queued_i,
    output logic [N_SLOTS-1:0]       join_o
);
    localparam logic [OCC_W-1:0] LIMIT = OCC_W'(OCC_LIMIT);

    for (genvar j = 0; j < N_SLOTS; j++) begin : g_slot
        logic room;
        assign room      = occ_i[j*OCC_W +: OCC_W] <= LIMIT;
        assign join_o[j] = run_i[j] && room && !br_i[j] && !pending_i[j] && !queued_i[j];
    end
endmodule

// File: rtl/wfa_order_queue.sv
module wfa_order_queue
    import wfa_pkg::*;
#(
    parameter int N_SLOTS = 4,
    parameter int IDW     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SLOTS-1:0] join_i,
    output logic               sel_valid_o,
    output logic [IDW-1:0]     sel_slot_o
);
    localparam int CW = $clog2(N_SLOTS + 1);

    wfa_state_e     state_q, state_n;
    logic [CW-1:0]  count_q, count_n;
    logic [IDW-1:0] q_q [N_SLOTS];
    logic [IDW-1:0] q_n [N_SLOTS];
    logic [IDW-1:0] lst [N_SLOTS];
    logic [CW-1:0]  len;

    // Merge the held entries with this edge's arrivals, oldest first.
    always_comb begin
        for (int i = 0; i < N_SLOTS; i++) lst[i] = q_q[i];
        len = count_q;
        for (int j = 0; j < N_SLOTS; j++) begin
            if (join_i[j] && (len < CW'(N_SLOTS))) begin
                lst[len[IDW-1:0]] = IDW'(j);
                len = len + 1'b1;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N_SLOTS - 1; i++) q_n[i] = lst[i+1];
        q_n[N_SLOTS-1] = '0;
        count_n = (len != '0) ? len - 1'b1 : '0;
        unique case (state_q)
            ST_EMPTY: state_n = (len > CW'(1)) ? ST_HOLD : ST_EMPTY;
            ST_HOLD:  state_n = (len > CW'(1)) ? ST_HOLD : ST_EMPTY;
            default:  state_n = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            count_q <= '0;
            for (int i = 0; i < N_SLOTS; i++) q_q[i] <= '0;
        end else begin
            state_q <= state_n;
            count_q <= count_n;
            for (int i = 0; i < N_SLOTS; i++) q_q[i] <= q_n[i];
        end
    end

    always_comb begin
        sel_valid_o = (len != '0);
        sel_slot_o  = (len != '0) ? lst[0] : '0;
    end

    p_hold_grants_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> sel_valid_o);
    p_empty_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY && join_i == '0) |-> !sel_valid_o);
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        count_q < CW'(N_SLOTS));
endmodule

// File: rtl/wfa_slot_flags.sv
module wfa_slot_flags #(
    parameter int N_SLOTS = 4,
    parameter int IDW     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SLOTS-1:0] join_i,
    input  logic               sel_valid_i,
    input  logic [IDW-1:0]     sel_slot_i,
    input  logic               ret_valid_i,
    input  logic [IDW-1:0]     ret_slot_i,
    output logic [N_SLOTS-1:0] pending_o,
    output logic [N_SLOTS-1:0] queued_o
);
    logic [N_SLOTS-1:0] take, drop;

    always_comb begin
        for (int j = 0; j < N_SLOTS; j++) begin
            take[j] = sel_valid_i && (sel_slot_i == IDW'(j));
            drop[j] = ret_valid_i && (ret_slot_i == IDW'(j));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_o <= '0;
            queued_o  <= '0;
        end else begin
            queued_o  <= (queued_o | join_i) & ~take;
            pending_o <= (pending_o | take) & ~(drop & ~take);
        end
    end

    for (genvar j = 0; j < N_SLOTS; j++) begin : g_chk
        p_ret_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (drop[j] && !take[j]) |=> !pending_o[j]);
        p_take_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
            take[j] |=> (pending_o[j] && !queued_o[j]));
    end
endmodule

// File: rtl/wave_fetch_arbiter.sv
module wave_fetch_arbiter #(
    parameter int N_SLOTS   = 4,
    parameter int OCC_W     = 4,
    parameter int OCC_LIMIT = 4,
    parameter int IDW       = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_SLOTS-1:0]       run_i,
    input  logic [N_SLOTS*OCC_W-1:0] occ_i,
    input  logic [N_SLOTS-1:0]       br_i,
    input  logic                     ret_valid_i,
    input  logic [IDW-1:0]           ret_slot_i,
    output logic                     grant_valid_o,
    output logic [IDW-1:0]           grant_slot_o,
    output logic [N_SLOTS-1:0]       pending_o,
    output logic [N_SLOTS-1:0]       queued_o
);
    logic [N_SLOTS-1:0] joins;
    logic               sel_valid;
    logic [IDW-1:0]     sel_slot;

    wfa_elig #(.N_SLOTS(N_SLOTS), .OCC_W(OCC_W), .OCC_LIMIT(OCC_LIMIT)) u_elig (
        .run_i(run_i), .occ_i(occ_i), .br_i(br_i),
        .pending_i(pending_o), .queued_i(queued_o), .join_o(joins)
    );

    wfa_order_queue #(.N_SLOTS(N_SLOTS), .IDW(IDW)) u_queue (
        .clk(clk), .rst_n(rst_n), .join_i(joins),
        .sel_valid_o(sel_valid), .sel_slot_o(sel_slot)
    );

    wfa_slot_flags #(.N_SLOTS(N_SLOTS), .IDW(IDW)) u_flags (
        .clk(clk), .rst_n(rst_n), .join_i(joins),
        .sel_valid_i(sel_valid), .sel_slot_i(sel_slot),
        .ret_valid_i(ret_valid_i), .ret_slot_i(ret_slot_i),
        .pending_o(pending_o), .queued_o(queued_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid_o <= 1'b0;
            grant_slot_o  <= '0;
        end else begin
            grant_valid_o <= sel_valid;
            grant_slot_o  <= sel_valid ? sel_slot : '0;
        end
    end

    p_grant_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |-> pending_o[grant_slot_o]);
    p_no_repeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |=> !(grant_valid_o && grant_slot_o == $past(grant_slot_o)));
    p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (queued_o & pending_o) == '0);
endmodule

// File: tb/sim_wave_fetch_arbiter.sv
module sim_wave_fetch_arbiter;
    localparam int N   = 4;
    localparam int OW  = 4;
    localparam int IDW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  run = '0;
    logic [N*OW-1:0] occ = '0;
    logic [N-1:0]  br = '0;
    logic          ret_v = 1'b0;
    logic [IDW-1:0] ret_s = '0;
    logic          g_v;
    logic [IDW-1:0] g_s;
    logic [N-1:0]  pend, qd;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    wave_fetch_arbiter #(.N_SLOTS(N), .OCC_W(OW), .OCC_LIMIT(4)) u0 (
        .clk(clk), .rst_n(rst_n), .run_i(run), .occ_i(occ), .br_i(br),
        .ret_valid_i(ret_v), .ret_slot_i(ret_s),
        .grant_valid_o(g_v), .grant_slot_o(g_s),
        .pending_o(pend), .queued_o(qd)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic grant_is(input string req, input bit v, input int s);
        chk(g_v == v, req, int'(g_v), int'(v));
        if (v) chk(int'(g_s) == s, req, int'(g_s), s);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; run = '0; occ = '0; br = '0; ret_v = 1'b0; ret_s = '0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic ret_one(input int s);
        ret_v = 1'b1; ret_s = IDW'(s);
        step();
        ret_v = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int mq[$];
        bit mp[N];
        bit mqd[N];
        logic [15:0] lf;
        do_reset();
        @(negedge clk);
        // R1: reset state
        chk(g_v == 0 && g_s == 0, "R1 grant", int'(g_v), 0);
        chk(pend == 0 && qd == 0, "R1 flags", int'({pend, qd}), 0);
        // R3: nothing eligible
        step();
        grant_is("R3 idle", 0, 0);
        // R2 / R5: slot 2 at the limit
        run[2] = 1; occ[2*OW +: OW] = 4;
        step();
        grant_is("R2 slot2 occ4", 1, 2);
        chk(pend == 4'b0100 && qd == 0, "R5 flags", int'({pend, qd}), 8'h40);
        step();
        grant_is("R10 pending blocks", 0, 0);
        ret_one(2);
        chk(pend == 0, "R8 cleared", int'(pend), 0);
        grant_is("R8 no grant at return edge", 0, 0);
        step();
        grant_is("R8 regrant", 1, 2);
        run[2] = 0; ret_one(2);
        occ[2*OW +: OW] = 5; run[2] = 1;
        step();
        grant_is("R2 occ5 blocked", 0, 0);
        occ[2*OW +: OW] = 4; br[2] = 1;
        step();
        grant_is("R2 branch blocked", 0, 0);
        br[2] = 0;
        step();
        grant_is("R2 branch cleared", 1, 2);
        run[2] = 0; ret_one(2);
        // R2 sweep of slot 1 over occupancy, branch and run
        for (int o = 0; o < 16; o++) begin
            for (int b = 0; b < 2; b++) begin
                for (int r = 0; r < 2; r++) begin
                    bit e;
                    e = (r == 1) && (o <= 4) && (b == 0);
                    run[1] = r[0]; br[1] = b[0]; occ[1*OW +: OW] = OW'(o);
                    step();
                    grant_is($sformatf("R2 sweep o=%0d b=%0d r=%0d", o, b, r), e, 1);
                    run[1] = 0; br[1] = 0;
                    ret_one(1);
                    chk(pend == 0 && qd == 0, "R8 sweep cleanup", int'({pend, qd}), 0);
                end
            end
        end
        occ = '0;
        // R7: simultaneous joins in ascending order
        run = 4'b1011;
        step();
        grant_is("R7 first", 1, 0);
        chk(qd == 4'b1010 && pend == 4'b0001, "R7 flags", int'({pend, qd}), 8'h1a);
        step();
        grant_is("R7 second", 1, 1);
        step();
        grant_is("R7 third", 1, 3);
        chk(pend == 4'b1011 && qd == 0, "R5 all pending", int'({pend, qd}), 8'hb0);
        step();
        grant_is("R10 all pending", 0, 0);
        run = '0;
        ret_one(0); ret_one(1); ret_one(3);
        // R6 / R9: older entries first, queued slot granted after losing run
        run = 4'b0110;
        step();
        grant_is("R6 first", 1, 1);
        run = 4'b1111;
        step();
        grant_is("R6 older slot2", 1, 2);
        chk(qd == 4'b1001, "R6 queued", int'(qd), 9);
        run = 4'b0001;
        br[3] = 1;
        step();
        grant_is("R6 slot0", 1, 0);
        step();
        grant_is("R9 slot3 while ineligible", 1, 3);
        step();
        grant_is("R9 no second grant", 0, 0);
        // Model-checked pseudo-random run (R2 R4 R5 R6 R7 R8 R9 R10)
        do_reset();
        @(negedge clk);
        mq.delete();
        for (int j = 0; j < N; j++) begin mp[j] = 0; mqd[j] = 0; end
        lf = 16'hACE1;
        for (int c = 0; c < 3000; c++) begin
            bit ev;
            int g;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            run = lf[3:0] | lf[7:4];
            for (int j = 0; j < N; j++) occ[j*OW +: OW] = OW'({1'b0, lf[(j*3) % 14 +: 3]});
            br = lf[11:8] & lf[15:12];
            ret_v = lf[2];
            ret_s = lf[6:5];
            for (int j = 0; j < N; j++) begin
                if (!mqd[j] && !mp[j] && run[j] && occ[j*OW +: OW] <= 4 && !br[j]) begin
                    mq.push_back(j); mqd[j] = 1;
                end
            end
            ev = mq.size() > 0;
            g = -1;
            if (ev) begin g = mq.pop_front(); mp[g] = 1; mqd[g] = 0; end
            if (ret_v && int'(ret_s) != g) mp[ret_s] = 0;
            step();
            grant_is("R6 model grant", ev, g);
            for (int j = 0; j < N; j++) begin
                chk(pend[j] == mp[j], "R8 model pending", int'(pend[j]), int'(mp[j]));
                chk(qd[j] == mqd[j], "R9 model queued", int'(qd[j]), int'(mqd[j]));
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule